// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block holds the coherence state of a single cache line on behalf of one core on a snooping shared bus. It takes local requests from the core (read, write, atomic read-modify-write, evict) over a valid/ready handshake. It decides whether the request can finish locally or needs a bus transaction. It raises that transaction through a request/grant handshake and commits the new state when the grant arrives. In parallel it answers transactions observed from other cores: it drives a shared indication, drives a flush indication when its dirty copy must be supplied, and moves the line to its next state.

The controller keeps a clean-exclusive state, so a core that holds the only copy can write without using the bus. A shared line is upgraded by an invalidate-only transaction that moves no data. An atomic read-modify-write always takes ownership first. Clean lines are dropped silently on eviction; only dirty lines are written back.

Back-pressure rules:
- Processor side: a request is taken on a cycle where `req_valid` and `req_ready` are both high. The core holds `req_op` steady until then.
- `req_ready` is low while a bus transaction is outstanding and on any cycle that carries a snoop, because snoops take priority.
- Bus side: `bus_req_valid` stays high until a cycle with `bus_gnt` high. That cycle completes the transaction.
- The environment never raises `bus_gnt` and `snp_valid` in the same cycle.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset the line is Invalid, with `line_state` encoded as Invalid=0, Shared=1, Exclusive=2, Modified=3. No bus request is raised, `rsp_valid` is low and `req_ready` is high.
- R2: A read (`req_op`=0) that hits in Shared, Exclusive or Modified finishes without bus traffic and without a state change. A read from Invalid raises a bus read (`bus_req_op`=1). At grant, the line installs as Exclusive when `bus_shared_in` is low and as Shared when it is high.
- R3: A write (`req_op`=1) or atomic read-modify-write (`req_op`=2) from Exclusive moves the line to Modified with no bus transaction. From Modified, either request finishes locally and the line stays Modified.
- R4: A write from Shared raises an upgrade (`bus_req_op`=3) and a write from Invalid raises a read-for-ownership (`bus_req_op`=2). In both cases the line becomes Modified at grant.
- R5: An atomic read-modify-write from Shared or Invalid raises a read-for-ownership (`bus_req_op`=2), never an upgrade, and the line becomes Modified at grant.
- R6: An evict (`req_op`=3) from Exclusive, Shared or Invalid drops the line to Invalid with no bus transaction. An evict from Modified raises a write-back (`bus_req_op`=4), and the line becomes Invalid at grant.
- R7: A snooped bus read (`snp_op`=1) acts by state:
  - Modified: assert both `snp_shared` and `snp_flush`, and go to Shared.
  - Exclusive: assert `snp_shared` without a flush, and go to Shared.
  - Shared: assert `snp_shared` and stay Shared.
  - Invalid: no response.
- R8: A snooped read-for-ownership (`snp_op`=2) or upgrade (`snp_op`=3) invalidates the line, asserting `snp_flush` only from Modified. Snoop codes 0 and 4, and any snoop while Invalid, change nothing and drive no response.
- R9: `req_ready` is high only with no outstanding bus request and no snoop in the cycle. `rsp_valid` is high for the cycle after a locally finished request is taken, and for the cycle after a grant.
- R10: An ungranted bus request stays raised, with an unchanged opcode, across idle cycles and across snoops that do not invalidate the line.
- R11: If a snoop invalidates the line while an upgrade is outstanding, the request turns into a read-for-ownership (`bus_req_op`=2) and the line reads Invalid. At grant the line becomes Modified.
- R12: If a snoop takes the line out of Modified while its write-back is outstanding, the snoop flush supplies the data. The write-back is then withdrawn without a grant, the line becomes Invalid and `rsp_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller can take a core request |
| req_op | input | 2 | Core request kind |
| rsp_valid | output | 1 | One-cycle completion pulse for the core |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_op | output | 3 | Kind of requested bus transaction |
| bus_gnt | input | 1 | Requested transaction completes this cycle |
| bus_shared_in | input | 1 | Wired shared indication, sampled with the grant |
| snp_valid | input | 1 | Another core's transaction is visible this cycle |
| snp_op | input | 3 | Kind of snooped transaction |
| snp_shared | output | 1 | This cache holds a copy (answer to a snooped read) |
| snp_flush | output | 1 | This cache supplies its dirty line |
| line_state | output | 2 | Current coherence state |

## Verification
The bench sweeps every starting state against every core request and both levels of the shared input, then every starting state against every snoop code. This catches a controller that installs Shared on a lone read miss, spends a transaction on an Exclusive write, or takes a silent upgrade for an atomic.

Outstanding-request races get directed tests:
- An invalidating snoop during an upgrade must turn it into a read-for-ownership. Otherwise the core would claim Modified without any data.
- A snoop during a dirty write-back must cancel it. Otherwise a stale write-back would follow the flush.
- A non-invalidating snoop must leave the pending opcode alone. A wrong design would change it or drop the request.

// File: rtl/coh_mesi_pkg.sv
package coh_mesi_pkg;
  localparam int ST_W = 2;
  localparam int PO_W = 2;
  localparam int BO_W = 3;

  typedef enum logic [ST_W-1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_e;

  typedef enum logic [PO_W-1:0] {
    PO_READ  = 2'd0,
    PO_WRITE = 2'd1,
    PO_RMW   = 2'd2,
    PO_EVICT = 2'd3
  } proc_op_e;

  typedef enum logic [BO_W-1:0] {
    BO_NONE = 3'd0,
    BO_RD   = 3'd1,
    BO_RDX  = 3'd2,
    BO_UPGR = 3'd3,
    BO_WB   = 3'd4
  } bus_op_e;

  typedef struct packed {
    line_st_e nxt;
    bus_op_e  bus;
  } local_dec_t;

  typedef struct packed {
    line_st_e nxt;
    logic     shared;
    logic     flush;
  } snoop_dec_t;
endpackage

// File: rtl/coh_req_decode.sv
module coh_req_decode
  import coh_mesi_pkg::*;
(
  input  line_st_e   st,
  input  proc_op_e   op,
  output local_dec_t dec
);
  always_comb begin
    dec.nxt = st;
    dec.bus = BO_NONE;
    unique case (op)
      PO_READ: begin
        if (st == LS_I) dec.bus = BO_RD;
      end
      PO_WRITE: begin
        case (st)
          LS_I:    dec.bus = BO_RDX;
          LS_S:    dec.bus = BO_UPGR;
          default: dec.nxt = LS_M;
        endcase
      end
      PO_RMW: begin
        if (st == LS_I || st == LS_S) dec.bus = BO_RDX;
        else                          dec.nxt = LS_M;
      end
      PO_EVICT: begin
        if (st == LS_M) dec.bus = BO_WB;
        else            dec.nxt = LS_I;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_grant_resolve.sv
module coh_grant_resolve
  import coh_mesi_pkg::*;
(
  input  bus_op_e  op,
  input  logic     shared_in,
  input  line_st_e cur,
  output line_st_e nxt
);
  always_comb begin
    case (op)
      BO_RD:           nxt = shared_in ? LS_S : LS_E;
      BO_RDX, BO_UPGR: nxt = LS_M;
      BO_WB:           nxt = LS_I;
      default:         nxt = cur;
    endcase
  end
endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
  import coh_mesi_pkg::*;
(
  input  logic       valid,
  input  bus_op_e    sop,
  input  line_st_e   st,
  output snoop_dec_t dec
);
  always_comb begin
    dec.nxt    = st;
    dec.shared = 1'b0;
    dec.flush  = 1'b0;
    if (valid && st != LS_I) begin
      case (sop)
        BO_RD: begin
          dec.nxt    = LS_S;
          dec.shared = 1'b1;
          dec.flush  = (st == LS_M);
        end
        BO_RDX, BO_UPGR: begin
          dec.nxt   = LS_I;
          dec.flush = (st == LS_M);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_mesi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PO_W-1:0] req_op,
  output logic            rsp_valid,
  output logic            bus_req_valid,
  output logic [BO_W-1:0] bus_req_op,
  input  logic            bus_gnt,
  input  logic            bus_shared_in,
  input  logic            snp_valid,
  input  logic [BO_W-1:0] snp_op,
  output logic            snp_shared,
  output logic            snp_flush,
  output logic [ST_W-1:0] line_state
);
  line_st_e   st_q, st_d, grant_nxt;
  bus_op_e    pop_q, pop_d;
  logic       pend_q, pend_d, rsp_q, rsp_d, accept;
  local_dec_t ldec;
  snoop_dec_t sdec;

  coh_req_decode u_dec (
    .st  (st_q),
    .op  (proc_op_e'(req_op)),
    .dec (ldec)
  );

  coh_grant_resolve u_grant (
    .op        (pop_q),
    .shared_in (bus_shared_in),
    .cur       (st_q),
    .nxt       (grant_nxt)
  );

  coh_snoop_resp u_snp (
    .valid (snp_valid),
    .sop   (bus_op_e'(snp_op)),
    .st    (st_q),
    .dec   (sdec)
  );

  assign req_ready = !pend_q && !snp_valid;
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    pop_d  = pop_q;
    rsp_d  = 1'b0;
    if (snp_valid) begin
      st_d = sdec.nxt;
      if (pend_q && pop_q == BO_UPGR && sdec.nxt == LS_I) begin
        pop_d = BO_RDX;
      end
      if (pend_q && pop_q == BO_WB && sdec.nxt != LS_M) begin
        st_d   = LS_I;
        pend_d = 1'b0;
        pop_d  = BO_NONE;
        rsp_d  = 1'b1;
      end
    end else if (pend_q && bus_gnt) begin
      st_d   = grant_nxt;
      pend_d = 1'b0;
      pop_d  = BO_NONE;
      rsp_d  = 1'b1;
    end else if (accept) begin
      if (ldec.bus == BO_NONE) begin
        st_d  = ldec.nxt;
        rsp_d = 1'b1;
      end else begin
        pend_d = 1'b1;
        pop_d  = ldec.bus;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= LS_I;
      pend_q <= 1'b0;
      pop_q  <= BO_NONE;
      rsp_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      pop_q  <= pop_d;
      rsp_q  <= rsp_d;
    end
  end

  assign rsp_valid     = rsp_q;
  assign bus_req_valid = pend_q;
  assign bus_req_op    = pop_q;
  assign snp_shared    = sdec.shared;
  assign snp_flush     = sdec.flush;
  assign line_state    = st_q;
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk
  import coh_mesi_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [PO_W-1:0] req_op,
  input logic            rsp_valid,
  input logic            bus_req_valid,
  input logic [BO_W-1:0] bus_req_op,
  input logic            bus_gnt,
  input logic            snp_valid,
  input logic [BO_W-1:0] snp_op,
  input logic            snp_shared,
  input logic            snp_flush,
  input logic [ST_W-1:0] line_state
);
  logic take;
  assign take = req_valid && req_ready;

  AST_SILENT_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    take && line_state == LS_E && (req_op == PO_WRITE || req_op == PO_RMW)
    |=> line_state == LS_M && !bus_req_valid && rsp_valid); // R3

  AST_UPGR_FROM_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    take && line_state == LS_S && req_op == PO_WRITE
    |=> bus_req_valid && bus_req_op == BO_UPGR); // R4

  AST_RMW_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_op == PO_RMW && (line_state == LS_S || line_state == LS_I)
    |=> bus_req_valid && bus_req_op == BO_RDX); // R5

  AST_SHARED_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |=> (line_state == LS_S || line_state == LS_I)); // R7

  AST_FLUSH_LEAVES_M: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |=> line_state != LS_M); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid || snp_valid) |-> !req_ready); // R9

  AST_GRANT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_gnt && !snp_valid |=> !bus_req_valid && rsp_valid); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_gnt && !snp_valid
    |=> bus_req_valid && $stable(bus_req_op)); // R10

  AST_UPGR_TO_RDX: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_op == BO_UPGR && snp_valid &&
    (snp_op == BO_RDX || snp_op == BO_UPGR) && line_state != LS_I
    |=> bus_req_valid && bus_req_op == BO_RDX && line_state == LS_I); // R11
endmodule

bind coh_line_ctrl coh_line_ctrl_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_op        (req_op),
  .rsp_valid     (rsp_valid),
  .bus_req_valid (bus_req_valid),
  .bus_req_op    (bus_req_op),
  .bus_gnt       (bus_gnt),
  .snp_valid     (snp_valid),
  .snp_op        (snp_op),
  .snp_shared    (snp_shared),
  .snp_flush     (snp_flush),
  .line_state    (line_state)
);

// File: tb/test_coh_line_ctrl.sv
`timescale 1ns/100ps
module test_coh_line_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, rsp_valid;
  logic [1:0] req_op;
  logic       bus_req_valid, bus_gnt, bus_shared_in;
  logic [2:0] bus_req_op;
  logic       snp_valid, snp_shared, snp_flush;
  logic [2:0] snp_op;
  logic [1:0] line_state;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  coh_line_ctrl i_coh_line_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .rsp_valid(rsp_valid), .bus_req_valid(bus_req_valid),
    .bus_req_op(bus_req_op), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_shared(snp_shared),
    .snp_flush(snp_flush), .line_state(line_state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_bus(int st, int op);
    case (op)
      0:       return (st == 0) ? 1 : 0;
      1:       return (st == 0) ? 2 : (st == 1) ? 3 : 0;
      2:       return (st <= 1) ? 2 : 0;
      default: return (st == 3) ? 4 : 0;
    endcase
  endfunction

  function automatic int exp_local(int st, int op);
    if (op == 0) return st;
    if (op == 3) return 0;
    return 3;
  endfunction

  function automatic int exp_grant(int b, bit sh);
    if (b == 1) return sh ? 1 : 2;
    if (b == 4) return 0;
    return 3;
  endfunction

  function automatic string local_tag(int st, int op);
    case (op)
      0:       return "R2";
      1:       return (st <= 1) ? "R4" : "R3";
      2:       return (st <= 1) ? "R5" : "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 0; req_op = 0; bus_gnt = 0; bus_shared_in = 0;
    snp_valid = 0; snp_op = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic local_op(input int op, input bit sh, input int st0);
    int eb;
    string t;
    eb = exp_bus(st0, op);
    t = local_tag(st0, op);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op);
    chk(req_ready == 1'b1, "R9 ready when idle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (eb == 0) begin
      chk(rsp_valid == 1'b1, "R9 local completion pulse", int'(rsp_valid), 1);
      chk(bus_req_valid == 1'b0, {t, " no bus traffic"}, int'(bus_req_valid), 0);
      chk(int'(line_state) == exp_local(st0, op), {t, " local next state"},
          int'(line_state), exp_local(st0, op));
    end else begin
      chk(bus_req_valid == 1'b1 && int'(bus_req_op) == eb, {t, " bus opcode"},
          int'(bus_req_op), eb);
      chk(rsp_valid == 1'b0 && req_ready == 1'b0, "R9 busy while pending",
          int'(req_ready), 0);
      @(negedge clk);
      chk(bus_req_valid == 1'b1 && int'(bus_req_op) == eb, "R10 request held",
          int'(bus_req_op), eb);
      bus_gnt = 1'b1; bus_shared_in = sh;
      @(negedge clk);
      bus_gnt = 1'b0; bus_shared_in = 1'b0;
      chk(rsp_valid == 1'b1 && bus_req_valid == 1'b0, "R9 grant completion",
          int'(rsp_valid), 1);
      chk(int'(line_state) == exp_grant(eb, sh), {t, " state after grant"},
          int'(line_state), exp_grant(eb, sh));
    end
  endtask

  task automatic goto_state(input int st);
    do_reset();
    case (st)
      1: local_op(0, 1'b1, 0);
      2: local_op(0, 1'b0, 0);
      3: local_op(1, 1'b0, 0);
      default: ;
    endcase
  endtask

  task automatic snoop_op(input int sop, input int st0);
    int en, es, ef;
    string t;
    t  = (sop == 1) ? "R7" : "R8";
    en = (st0 == 0) ? 0 : (sop == 1) ? 1 : (sop == 2 || sop == 3) ? 0 : st0;
    es = (st0 != 0 && sop == 1) ? 1 : 0;
    ef = (st0 == 3 && sop >= 1 && sop <= 3) ? 1 : 0;
    @(negedge clk);
    snp_valid = 1'b1; snp_op = 3'(sop);
    #1;
    chk(int'(snp_shared) == es, {t, " shared response"}, int'(snp_shared), es);
    chk(int'(snp_flush) == ef, {t, " flush response"}, int'(snp_flush), ef);
    chk(req_ready == 1'b0, "R9 snoop blocks requests", int'(req_ready), 0);
    @(negedge clk);
    snp_valid = 1'b0;
    chk(int'(line_state) == en, {t, " state after snoop"}, int'(line_state), en);
  endtask

  task automatic pend_then_snoop(input int st0, input int op, input int sop);
    goto_state(st0);
    @(negedge clk); req_valid = 1'b1; req_op = 2'(op);
    @(negedge clk); req_valid = 1'b0;
    snp_valid = 1'b1; snp_op = 3'(sop);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(line_state == 2'd0 && bus_req_valid == 1'b0 && rsp_valid == 1'b0 &&
        req_ready == 1'b1, "R1 reset state", int'(line_state), 0);

    for (int st = 0; st < 4; st++)
      for (int op = 0; op < 4; op++)
        for (int sh = 0; sh < 2; sh++) begin
          goto_state(st);
          local_op(op, sh[0], st);
        end

    for (int st = 0; st < 4; st++)
      for (int sop = 0; sop < 5; sop++) begin
        goto_state(st);
        snoop_op(sop, st);
      end

    // R11: invalidating snoop during an upgrade
    for (int sop = 2; sop < 4; sop++) begin
      pend_then_snoop(1, 1, sop);
      @(negedge clk); snp_valid = 1'b0;
      chk(bus_req_valid == 1'b1 && bus_req_op == 3'd2, "R11 upgrade converted",
          int'(bus_req_op), 2);
      chk(line_state == 2'd0, "R11 line invalid while pending", int'(line_state), 0);
      bus_gnt = 1'b1;
      @(negedge clk); bus_gnt = 1'b0;
      chk(line_state == 2'd3 && rsp_valid == 1'b1, "R11 modified after grant",
          int'(line_state), 3);
    end

    // R10: non-invalidating snoop leaves the upgrade alone
    pend_then_snoop(1, 1, 1);
    chk(snp_shared == 1'b1, "R7 shared while upgrade pending", int'(snp_shared), 1);
    @(negedge clk); snp_valid = 1'b0;
    chk(bus_req_valid == 1'b1 && bus_req_op == 3'd3 && line_state == 2'd1,
        "R10 upgrade kept", int'(bus_req_op), 3);

    // R12: snoop during dirty write-back
    for (int sop = 1; sop < 4; sop++) begin
      pend_then_snoop(3, 3, sop);
      chk(snp_flush == 1'b1, "R12 flush during write-back", int'(snp_flush), 1);
      @(negedge clk); snp_valid = 1'b0;
      chk(bus_req_valid == 1'b0, "R12 write-back withdrawn", int'(bus_req_valid), 0);
      chk(rsp_valid == 1'b1 && line_state == 2'd0, "R12 eviction complete",
          int'(line_state), 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule